// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block sits beside a two-port shared memory and turns the two highest words of that memory into mailboxes. Each port owns one mailbox. When one port stores a word into the other port's mailbox, the owner gets an active-low interrupt flag. The owner clears the flag by reading its own mailbox. The memory itself still stores the message. This block only follows the access strobes on both ports and keeps the two flags.

The highest address belongs to the right port and the address just below it belongs to the left port. Every access is sampled on the rising clock edge, and a flag changes in the cycle after the access that caused the change. Each port also has a busy input that comes from the memory arbiter. While busy is active on a port, that port's access has no effect on either flag. The arbiter that drives busy is outside this block.

Top module: `mbx_irq`

## Requirements
- R1: While reset is active, and after it is released, both flags are high (inactive).
- R2: A left-port write (cs=1, we=1) to address 2^ADDR_W-1 with left busy low drives r_irq_no low on the next cycle.
- R3: A right-port write (cs=1, we=1) to address 2^ADDR_W-2 with right busy low drives l_irq_no low on the next cycle.
- R4: A read (cs=1, we=0, oe=1) with busy low of a port's own mailbox (right: 2^ADDR_W-1, left: 2^ADDR_W-2) returns that port's flag high on the next cycle.
- R5: A port that reads the other port's mailbox changes neither flag.
- R6: When a port's busy is high, its write to the other mailbox does not set the other port's flag.
- R7: When a port's busy is high, its read of its own mailbox does not clear its own flag.
- R8: These change no flag: a write by a port to its own mailbox, any access with cs=0, and a read with oe=0.
- R9: If a set and a clear of the same flag happen in the same cycle, the flag ends up low (set wins).
- R10: When a cycle has neither a set nor a clear for a flag, that flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_cs_i | input | 1 | Left chip select, active high |
| l_we_i | input | 1 | Left write strobe (1 = write, 0 = read) |
| l_oe_i | input | 1 | Left output enable, active high |
| l_addr_i | input | ADDR_W | Left word address |
| l_busy_i | input | 1 | Left arbitration busy, active high |
| r_cs_i | input | 1 | Right chip select, active high |
| r_we_i | input | 1 | Right write strobe (1 = write, 0 = read) |
| r_oe_i | input | 1 | Right output enable, active high |
| r_addr_i | input | ADDR_W | Right word address |
| r_busy_i | input | 1 | Right arbitration busy, active high |
| l_irq_no | output | 1 | Left interrupt flag, active low |
| r_irq_no | output | 1 | Right interrupt flag, active low |

## Verification
The bench runs a small 4-bit address configuration. It sweeps every address pair against every access type on both ports and every busy combination, and it checks both flags against an arithmetic model after each cycle. Directed sequences target the known corner cases. A design that swapped the two mailbox addresses would raise the wrong flag. A design that let a cross read clear a flag would lose a message that had not been read. A design that ignored busy would accept a contended access. A design that gave the clear priority would drop a message posted in the same cycle as the owner's read. Reads with output enable low and writes to the port's own mailbox are also driven, to catch decode that ignores the strobes.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic {
    SIDE_L = 1'b0,
    SIDE_R = 1'b1
  } side_e;

  localparam int unsigned NUM_SIDES = 2;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W = 14,
  parameter side_e       SIDE   = SIDE_L
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic              oe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_i,
  output logic              post_o,  // write into peer mailbox
  output logic              ack_o    // read of own mailbox
);
  localparam logic [ADDR_W-1:0] MBX_TOP  = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] MBX_OWN  = (SIDE == SIDE_R) ? MBX_TOP : MBX_TOP - 1'b1;
  localparam logic [ADDR_W-1:0] MBX_PEER = (SIDE == SIDE_R) ? MBX_TOP - 1'b1 : MBX_TOP;

  logic granted;
  logic hit_own, hit_peer;

  assign granted  = cs_i && !busy_i;
  assign hit_own  = (addr_i == MBX_OWN);
  assign hit_peer = (addr_i == MBX_PEER);

  assign post_o = granted && we_i && hit_peer;
  assign ack_o  = granted && !we_i && oe_i && hit_own;

  // R6 / R7: a busy port produces no flag event
  assert_busy_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (!post_o && !ack_o));

  // R8: deselected port produces no event
  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |-> (!post_o && !ack_o));
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_no <= 1'b1;
    else if (set_i)  flag_no <= 1'b0;  // set wins, R9
    else if (clr_i)  flag_no <= 1'b1;
  end

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && clr_i) |=> !flag_no);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(flag_no));
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_cs_i,
  input  logic              l_we_i,
  input  logic              l_oe_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              l_busy_i,
  input  logic              r_cs_i,
  input  logic              r_we_i,
  input  logic              r_oe_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic              r_busy_i,
  output logic              l_irq_no,
  output logic              r_irq_no
);
  localparam int unsigned NS = NUM_SIDES;

  logic              cs   [NS];
  logic              we   [NS];
  logic              oe   [NS];
  logic [ADDR_W-1:0] addr [NS];
  logic              busy [NS];
  logic              post [NS];
  logic              ack  [NS];
  logic              irq_n[NS];

  assign cs[0]   = l_cs_i;   assign cs[1]   = r_cs_i;
  assign we[0]   = l_we_i;   assign we[1]   = r_we_i;
  assign oe[0]   = l_oe_i;   assign oe[1]   = r_oe_i;
  assign addr[0] = l_addr_i; assign addr[1] = r_addr_i;
  assign busy[0] = l_busy_i; assign busy[1] = r_busy_i;

  assign l_irq_no = irq_n[0];
  assign r_irq_no = irq_n[1];

  for (genvar s = 0; s < NS; s++) begin : g_side
    localparam int unsigned PEER = NS - 1 - s;

    mbx_port_decode #(
      .ADDR_W (ADDR_W),
      .SIDE   (side_e'(s))
    ) u_dec (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cs_i   (cs[s]),
      .we_i   (we[s]),
      .oe_i   (oe[s]),
      .addr_i (addr[s]),
      .busy_i (busy[s]),
      .post_o (post[s]),
      .ack_o  (ack[s])
    );

    // flag s is set by the peer's post, cleared by own ack
    mbx_flag u_flag (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (post[PEER]),
      .clr_i   (ack[s]),
      .flag_no (irq_n[s])
    );

    // R2 / R3
    assert_post_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      post[PEER] |=> !irq_n[s]);

    assert_ack_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack[s] && !post[PEER]) |=> irq_n[s]);

    // R5 / R8: only the peer's post may lower a flag
    assert_no_spurious_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_n[s] && !post[PEER]) |=> irq_n[s]);
  end
endmodule

// File: tb/mbx_irq_test.sv
`timescale 1ns/1ps
module mbx_irq_test;
  localparam int unsigned AW = 4;
  localparam logic [AW-1:0] MB_R = {AW{1'b1}};
  localparam logic [AW-1:0] MB_L = {AW{1'b1}} - 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_cs = 0, l_we = 0, l_oe = 0, l_busy = 0;
  logic r_cs = 0, r_we = 0, r_oe = 0, r_busy = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_irq_n, r_irq_n;
  logic exp_l = 1'b1, exp_r = 1'b1;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mbx_irq #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .l_cs_i(l_cs), .l_we_i(l_we), .l_oe_i(l_oe), .l_addr_i(l_addr), .l_busy_i(l_busy),
    .r_cs_i(r_cs), .r_we_i(r_we), .r_oe_i(r_oe), .r_addr_i(r_addr), .r_busy_i(r_busy),
    .l_irq_no(l_irq_n), .r_irq_no(r_irq_n)
  );

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // drive one cycle, update model, compare both flags after the edge
  task automatic step(string tag,
                      logic lc, logic lw, logic lo, logic [AW-1:0] la, logic lb,
                      logic rc, logic rw, logic ro, logic [AW-1:0] ra, logic rb);
    logic set_l, clr_l, set_r, clr_r;
    l_cs = lc; l_we = lw; l_oe = lo; l_addr = la; l_busy = lb;
    r_cs = rc; r_we = rw; r_oe = ro; r_addr = ra; r_busy = rb;
    set_r = lc && lw && !lb && (la == MB_R);
    clr_r = rc && !rw && ro && !rb && (ra == MB_R);
    set_l = rc && rw && !rb && (ra == MB_L);
    clr_l = lc && !lw && lo && !lb && (la == MB_L);
    @(posedge clk);
    @(negedge clk);
    exp_r = set_r ? 1'b0 : (clr_r ? 1'b1 : exp_r);
    exp_l = set_l ? 1'b0 : (clr_l ? 1'b1 : exp_l);
    check(tag, "l_irq_no", l_irq_n, exp_l);
    check(tag, "r_irq_no", r_irq_n, exp_r);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "l_irq_no in reset", l_irq_n, 1'b1);
    check("R1", "r_irq_no in reset", r_irq_n, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "l_irq_no after reset", l_irq_n, 1'b1);
    check("R1", "r_irq_no after reset", r_irq_n, 1'b1);

    step("R2",  1,1,0,MB_R,0, 0,0,0,0,0);
    check("R2", "right flag set", r_irq_n, 1'b0);
    step("R5",  1,0,1,MB_R,0, 0,0,0,0,0);      // left reads right mailbox
    step("R8",  0,0,0,0,0,    1,1,0,MB_R,0);   // right writes own mailbox
    step("R8",  0,0,0,0,0,    1,0,0,MB_R,0);   // read with oe low
    step("R8",  0,0,0,0,0,    0,0,1,MB_R,0);   // cs low
    step("R7",  0,0,0,0,0,    1,0,1,MB_R,1);
    check("R7", "right flag held", r_irq_n, 1'b0);
    step("R4",  0,0,0,0,0,    1,0,1,MB_R,0);
    check("R4", "right flag cleared", r_irq_n, 1'b1);
    step("R6",  1,1,0,MB_R,1, 0,0,0,0,0);
    check("R6", "right flag not set", r_irq_n, 1'b1);
    step("R3",  0,0,0,0,0,    1,1,0,MB_L,0);
    check("R3", "left flag set", l_irq_n, 1'b0);
    step("R5",  0,0,0,0,0,    1,0,1,MB_L,0);   // right reads left mailbox
    step("R8",  1,1,0,MB_L,0, 0,0,0,0,0);      // left writes own mailbox
    step("R9",  1,0,1,MB_L,0, 1,1,0,MB_L,0);
    check("R9", "left set wins", l_irq_n, 1'b0);
    step("R9",  1,1,0,MB_R,0, 1,0,1,MB_R,0);
    check("R9", "right set wins", r_irq_n, 1'b0);
    step("R10", 0,0,0,0,0,    0,0,0,0,0);
    step("R4",  1,0,1,MB_L,0, 1,0,1,MB_R,0);
    check("R4", "left flag cleared", l_irq_n, 1'b1);

    // sweep: op 0 idle (cs low), 1 write, 2 read, 3 read with oe low
    for (int la = 0; la < (1 << AW); la++)
      for (int ra = 0; ra < (1 << AW); ra++)
        for (int ops = 0; ops < 16; ops++)
          for (int bz = 0; bz < 4; bz++) begin
            int lop = ops % 4;
            int rop = ops / 4;
            step("R10",
                 lop != 0, lop == 1, lop == 2, AW'(la), bz[0],
                 rop != 0, rop == 1, rop == 2, AW'(ra), bz[1]);
          end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule